// File: doc/BRIEF.md
# Multi-core VP run/stop controller

This block keeps a record of which virtual processors (VPs) are running on each of several physical cores. Software controls it through a small memory-mapped register set. A stop write carries a bitmask of VPs to halt, and a run write carries a bitmask of VPs to start. For every VP whose state really changes, the block raises a one-clock pulse on a flat per-VP output vector. A start pulse means "release from reset and run". A halt pulse means "stop this VP". Software can read back the running mask of a core. It can also read a fixed status/config word.

There are two address windows with the same layout. Accesses through the local window at base 0x0000 act on the core that issued them, given by a requester ID input. Accesses through the other-core window at base 0x4000 act on the core named by a redirect input. After reset every mask is empty, and then a start set fixed at elaboration is started on core 0. Global VP number g belongs to core g / VPS_PER_CORE at index g mod VPS_PER_CORE. It sits at bit c*VPS_PER_CORE + i of the pulse vectors.

Top module: `vp_power_ctrl`

## Requirements
- R1: While `rst` is high, every core's running mask is cleared, `vp_start` and `vp_halt` are zero and `rd_valid` is low.
- R2: In the first clock after `rst` falls, VPs of core 0 whose bit is set in `START_MASK` get a start pulse and are marked running. Bits of `START_MASK` at or above `VPS_PER_CORE` are ignored, and no other core is touched.
- R3: An access whose address has bit 14 clear (window base 0x0000) targets core `req_core`. An access with bit 14 set (window base 0x4000) targets core `redir_core`.
- R4: A write to window offset 0x28 (run) starts exactly those VPs of the target core whose data bit is set and which are not already running. The pulse appears on `vp_start` in the cycle after the write.
- R5: A write to window offset 0x20 (stop) halts exactly those VPs of the target core whose data bit is set and which are running. The pulse appears on `vp_halt` in the cycle after the write.
- R6: A read of window offset 0x30 returns the target core's running mask, zero-extended to 64 bits, with `rd_valid` high in the cycle after the read.
- R7: A read of window offset 0x08 returns 0x0000_0000_0038_0000, which is the value 7 at bit 19 with all other bits zero.
- R8: Reads of any other address return zero with `rd_valid` high. Writes to any other address change no mask and give no pulse. Data bits at or above `VPS_PER_CORE` in run and stop writes have no effect.
- R9: Every start and halt pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data (VP bitmask) |
| req_core | input | CORE_W | Core that issued the access |
| redir_core | input | CORE_W | Target core for other-core window accesses |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | DATA_W | Read data |
| vp_start | output | NUM_CORES*VPS_PER_CORE | One-clock start pulse per global VP |
| vp_halt | output | NUM_CORES*VPS_PER_CORE | One-clock halt pulse per global VP |

## Verification
A wrong running bit has two visible effects. It shows up at once on the next running-mask read. It also shows up in the pulse vectors of the next run or stop write to that core: a missing pulse, or a pulse on a VP that should have been filtered out. A wrong target core appears one cycle after the write, as a pulse at the wrong position in the flat vector. The bench therefore follows every run or stop write with pulse checks in the next cycle, and checks the masks through reads in both windows.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_RUN,
    ACC_STOP,
    ACC_RD_MASK,
    ACC_RD_STATUS,
    ACC_RD_ZERO
  } acc_e;

  localparam logic [5:0] OFS_STATUS = 6'h08;
  localparam logic [5:0] OFS_STOP   = 6'h20;
  localparam logic [5:0] OFS_RUN    = 6'h28;
  localparam logic [5:0] OFS_MASK   = 6'h30;

  localparam int WIN_SEL_BIT = 14;

  localparam int          SEQ_STATE_POS = 19;
  localparam logic [63:0] SEQ_STATE_VAL = 64'd7;

endpackage

// File: rtl/vpc_decode.sv
module vpc_decode
  import vpc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_CORES = 2,
  parameter int CORE_W    = 1
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CORE_W-1:0] req_core,
  input  logic [CORE_W-1:0] redir_core,
  output acc_e              kind,
  output logic [CORE_W-1:0] tgt_core
);

  localparam logic [ADDR_W-1:0] USED_BITS =
    ADDR_W'((64'd1 << WIN_SEL_BIT) | 64'h3F);

  logic       addr_ok;
  logic       core_ok;
  logic [5:0] ofs;

  always_comb begin
    ofs      = bus_addr[5:0];
    addr_ok  = (bus_addr & ~USED_BITS) == '0;
    tgt_core = bus_addr[WIN_SEL_BIT] ? redir_core : req_core;
    core_ok  = 32'(tgt_core) < NUM_CORES;
    kind     = ACC_NONE;
    if (bus_valid) begin
      if (bus_write) begin
        if (addr_ok && core_ok && ofs == OFS_RUN)       kind = ACC_RUN;
        else if (addr_ok && core_ok && ofs == OFS_STOP) kind = ACC_STOP;
      end else begin
        if (addr_ok && core_ok && ofs == OFS_MASK) kind = ACC_RD_MASK;
        else if (addr_ok && ofs == OFS_STATUS)     kind = ACC_RD_STATUS;
        else                                       kind = ACC_RD_ZERO;
      end
    end
  end

endmodule

// File: rtl/vpc_core_slot.sv
module vpc_core_slot #(
  parameter int NVP = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NVP-1:0] run_req,
  input  logic [NVP-1:0] stop_req,
  output logic [NVP-1:0] running_q,
  output logic [NVP-1:0] start_q,
  output logic [NVP-1:0] halt_q
);

  logic [NVP-1:0] start_d;
  logic [NVP-1:0] halt_d;

  always_comb begin
    start_d = run_req & ~running_q;
    halt_d  = stop_req & running_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= '0;
      start_q   <= '0;
      halt_q    <= '0;
    end else begin
      running_q <= (running_q | start_d) & ~halt_d;
      start_q   <= start_d;
      halt_q    <= halt_d;
    end
  end

  // R4
  start_filter_chk: assert property (@(posedge clk) disable iff (rst)
    (|start_q) |-> (((start_q & $past(running_q)) == '0) && ((start_q & ~running_q) == '0)));

  // R5
  halt_filter_chk: assert property (@(posedge clk) disable iff (rst)
    (|halt_q) |-> (((halt_q & ~$past(running_q)) == '0) && ((halt_q & running_q) == '0)));

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (|(start_q | halt_q)) |=> (((start_q & $past(start_q)) == '0) && ((halt_q & $past(halt_q)) == '0)));

endmodule

// File: rtl/vp_power_ctrl.sv
module vp_power_ctrl
  import vpc_pkg::*;
#(
  parameter int          NUM_CORES    = 2,
  parameter int          VPS_PER_CORE = 4,
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 64,
  parameter logic [63:0] START_MASK   = 64'h1,
  parameter int          CORE_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_valid,
  input  logic                              bus_write,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [DATA_W-1:0]                 bus_wdata,
  input  logic [CORE_W-1:0]                 req_core,
  input  logic [CORE_W-1:0]                 redir_core,
  output logic                              rd_valid,
  output logic [DATA_W-1:0]                 rd_data,
  output logic [NUM_CORES*VPS_PER_CORE-1:0] vp_start,
  output logic [NUM_CORES*VPS_PER_CORE-1:0] vp_halt
);

  localparam int NVP = VPS_PER_CORE;
  localparam logic [NVP-1:0]    BOOT_BITS   = START_MASK[NVP-1:0];
  localparam logic [DATA_W-1:0] STATUS_WORD = DATA_W'(SEQ_STATE_VAL << SEQ_STATE_POS);

  acc_e              kind;
  logic [CORE_W-1:0] tgt_core;
  logic              boot_q;
  logic [NVP-1:0]    run_mask [NUM_CORES];
  logic [NVP-1:0]    sel_mask;
  logic [DATA_W-1:0] rd_next;

  vpc_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_CORES(NUM_CORES),
    .CORE_W   (CORE_W)
  ) u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .req_core  (req_core),
    .redir_core(redir_core),
    .kind      (kind),
    .tgt_core  (tgt_core)
  );

  always_ff @(posedge clk) begin
    if (rst) boot_q <= 1'b1;
    else     boot_q <= 1'b0;
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic           hit;
    logic [NVP-1:0] run_req;
    logic [NVP-1:0] stop_req;

    always_comb begin
      hit      = (32'(tgt_core) == c);
      run_req  = (hit && kind == ACC_RUN)  ? bus_wdata[NVP-1:0] : '0;
      stop_req = (hit && kind == ACC_STOP) ? bus_wdata[NVP-1:0] : '0;
      if (c == 0 && boot_q) run_req = run_req | BOOT_BITS;
    end

    vpc_core_slot #(.NVP(NVP)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .run_req  (run_req),
      .stop_req (stop_req),
      .running_q(run_mask[c]),
      .start_q  (vp_start[c*NVP +: NVP]),
      .halt_q   (vp_halt[c*NVP +: NVP])
    );
  end

  always_comb begin
    sel_mask = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (32'(tgt_core) == c) sel_mask = run_mask[c];
    end
    case (kind)
      ACC_RD_MASK:   rd_next = DATA_W'(sel_mask);
      ACC_RD_STATUS: rd_next = STATUS_WORD;
      default:       rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_valid && !bus_write;
      rd_data  <= rd_next;
    end
  end

  // R6
  rd_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_valid && !bus_write));

  // R7
  status_word_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(kind == ACC_RD_STATUS)) |-> (rd_data == STATUS_WORD));

  // R2
  boot_start_chk: assert property (@(posedge clk) disable iff (rst)
    boot_q |=> ((vp_start[NVP-1:0] & BOOT_BITS) == BOOT_BITS));

  // R8
  undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && kind == ACC_NONE && !boot_q) |=> (vp_start == '0 && vp_halt == '0));

endmodule

// File: tb/vp_power_ctrl_test.sv
module vp_power_ctrl_test;

  localparam int NC  = 2;
  localparam int NV  = 4;
  localparam int TOT = NC * NV;
  localparam logic [63:0] SMASK = 64'h35;

  typedef struct {
    logic [TOT-1:0] start;
    logic [TOT-1:0] halt;
    logic           rdv;
    logic [63:0]    rdata;
    string          tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst;
  logic           bus_valid;
  logic           bus_write;
  logic [15:0]    bus_addr;
  logic [63:0]    bus_wdata;
  logic [0:0]     req_core;
  logic [0:0]     redir_core;
  logic           rd_valid;
  logic [63:0]    rd_data;
  logic [TOT-1:0] vp_start;
  logic [TOT-1:0] vp_halt;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic [NV-1:0] model [NC];

  always #5 clk = ~clk;

  vp_power_ctrl #(
    .NUM_CORES   (NC),
    .VPS_PER_CORE(NV),
    .START_MASK  (SMASK)
  ) uut (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .req_core  (req_core),
    .redir_core(redir_core),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .vp_start  (vp_start),
    .vp_halt   (vp_halt)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one bus cycle, model computed from the requirements.
  task automatic access(logic wr, logic [15:0] addr, logic [63:0] data,
                        logic [0:0] rq, logic [0:0] rd, string tag);
    exp_t e;
    int tgt;
    logic ok;
    logic [NV-1:0] bits;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = addr;
    bus_wdata = data; req_core = rq; redir_core = rd;
    e.start = '0; e.halt = '0; e.rdv = !wr; e.rdata = '0; e.tag = tag;
    ok  = (addr & ~16'h403F) == 16'h0;
    tgt = addr[14] ? int'(rd) : int'(rq);
    if (wr && ok && addr[5:0] == 6'h28) begin
      bits = data[NV-1:0] & ~model[tgt];
      model[tgt] = model[tgt] | bits;
      e.start[tgt*NV +: NV] = bits;
    end else if (wr && ok && addr[5:0] == 6'h20) begin
      bits = data[NV-1:0] & model[tgt];
      model[tgt] = model[tgt] & ~bits;
      e.halt[tgt*NV +: NV] = bits;
    end else if (!wr && ok && addr[5:0] == 6'h30) begin
      e.rdata = 64'(model[tgt]);
    end else if (!wr && ok && addr[5:0] == 6'h08) begin
      e.rdata = 64'h0000_0000_0038_0000;
    end
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    exp_t e;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    e.start = '0; e.halt = '0; e.rdv = 1'b0; e.rdata = '0; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares the result of each driven cycle after the edge.
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({e.tag, " start"}, 64'(vp_start), 64'(e.start));
        check({e.tag, " halt"},  64'(vp_halt),  64'(e.halt));
        check({e.tag, " rdv"},   64'(rd_valid), 64'(e.rdv));
        if (e.rdv) check({e.tag, " rdata"}, rd_data, e.rdata);
      end
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_t e;
    rst = 1'b1; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_wdata = '0; req_core = '0; redir_core = '0;
    for (int c = 0; c < NC; c++) model[c] = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1 start", 64'(vp_start), 64'h0);
    check("R1 halt", 64'(vp_halt), 64'h0);
    check("R1 rdv", 64'(rd_valid), 64'h0);

    // R2 boot start on core 0, bits above VP count ignored
    @(negedge clk);
    rst = 1'b0;
    model[0] = SMASK[NV-1:0];
    e.start = '0; e.start[NV-1:0] = SMASK[NV-1:0];
    e.halt = '0; e.rdv = 1'b0; e.rdata = '0; e.tag = "R2 boot";
    q.push_back(e);
    idle("R9 boot pulse ends");

    // R6 and R3: mask via local window and other-core window
    access(1'b0, 16'h0030, 64'h0, 1'b0, 1'b1, "R6 R3 local mask core0");
    access(1'b0, 16'h4030, 64'h0, 1'b0, 1'b1, "R6 R3 other mask core1");
    // R7 status in both windows
    access(1'b0, 16'h0008, 64'h0, 1'b1, 1'b0, "R7 status local");
    access(1'b0, 16'h4008, 64'h0, 1'b0, 1'b1, "R7 status other");
    // R4 run from core 1 local
    access(1'b1, 16'h0028, 64'h3, 1'b1, 1'b0, "R4 R3 run core1");
    idle("R9 run pulse ends");
    access(1'b1, 16'h0028, 64'h7, 1'b1, 1'b0, "R4 run filters running");
    // R5 stop core 0 via other window, VP3 not running
    access(1'b1, 16'h4020, 64'hC, 1'b1, 1'b0, "R5 R3 stop core0");
    idle("R9 halt pulse ends");
    access(1'b1, 16'h4020, 64'hC, 1'b1, 1'b0, "R5 stop nothing running");
    // R8 undefined offsets and high data bits
    access(1'b0, 16'h0010, 64'h0, 1'b0, 1'b0, "R8 undef read");
    access(1'b1, 16'h0010, 64'hF, 1'b0, 1'b0, "R8 undef write");
    access(1'b1, 16'h1028, 64'hF, 1'b0, 1'b0, "R8 bad window write");
    access(1'b1, 16'h0028, 64'hF0, 1'b0, 1'b0, "R8 high data bits");
    access(1'b0, 16'h0030, 64'h0, 1'b0, 1'b0, "R8 R6 mask core0 unchanged");
    access(1'b0, 16'h4030, 64'h0, 1'b0, 1'b1, "R6 mask core1");
    // R4 R5 other window to core 1
    access(1'b1, 16'h4020, 64'h5, 1'b0, 1'b1, "R5 stop core1 other");
    access(1'b1, 16'h4028, 64'hF, 1'b0, 1'b1, "R4 run core1 other");
    access(1'b0, 16'h0030, 64'h0, 1'b1, 1'b0, "R6 mask core1 local");
    idle("tail");
    repeat (3) @(posedge clk);
    #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule